// File: doc/BRIEF.md
# Home-Node Coherence Directory

This block is the home node for a small region of shared memory in a four-processor distributed shared-memory system. For every memory block it holds a directory entry with a state (not cached, shared read-only, or owned read/write) and a bit-vector with one bit per processor. It also holds the block data in an internal array. Processors send it read misses, write misses and evictions of dirty blocks. The directory answers each miss with a data reply to the requester. Where coherence demands it, it first sends targeted commands to remote caches: invalidate, fetch, or fetch-and-invalidate.

Requests are served one at a time. A write miss to a shared block walks the sharer vector and sends one invalidate per cycle before the reply. A miss to an owned block sends a fetch to the owner and then waits on a separate fill channel for the owner's data. That data is written to memory and forwarded to the requester. While a request is in progress, `req_ready` is low.

Top module: `coh_home_dir`

## Requirements
- R1: After reset, `req_ready` is 1 and `rep_valid`/`cmd_valid` are 0. Every block is not cached, and block i holds data 32'hC0DE_0000 + i. A reset also abandons a request that is waiting for a fill.
- R2: A read miss (`req_kind`=0) to a block that is not cached gives a reply to the requester in the cycle after acceptance, carrying the memory data and with no command. The block becomes shared, with the requester as its only sharer.
- R3: A read miss to a shared block gives a memory-data reply in the cycle after acceptance and adds the requester to the sharers. No command is sent.
- R4: A write miss (`req_kind`=1) to a block that is not cached gives a memory-data reply in the cycle after acceptance. The block becomes owned by the requester.
- R5: A write miss to a shared block sends an invalidate (`cmd_kind`=1) to each sharer other than the requester. These go out one per cycle in ascending processor number, starting two cycles after acceptance. The memory-data reply comes in the cycle after the last invalidate, `req_ready` stays low until then, and the block becomes owned by the requester alone.
- R6: A read miss to an owned block sends a fetch (`cmd_kind`=2) to the owner in the cycle after acceptance and holds `req_ready` low. In the cycle after `fill_valid`, the fill data is replied to the requester and written to memory. The block becomes shared by the old owner and the requester.
- R7: A write miss to an owned block sends fetch-and-invalidate (`cmd_kind`=3) to the owner. In the cycle after `fill_valid`, it replies with the fill data, and the requester becomes the only owner.
- R8: An eviction (`req_kind`=2) from the owner of an owned block writes `req_data` to memory and makes the block not cached. It produces no reply and no command.
- R9: An eviction from a processor that is not the owner, an eviction of a block that is not owned, and `req_kind`=3 are all ignored. They leave the state and data unchanged, with no reply and no command.
- R10: Each accepted miss gives exactly one reply, one cycle wide. A reply and a command are never valid in the same cycle. Every command carries the requested block in `cmd_blk`.
- R11: `fill_valid` while no fetch is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can accept a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 eviction, 3 reserved |
| req_src | input | 2 | Requesting processor |
| req_blk | input | 4 | Block index |
| req_data | input | 32 | Eviction data |
| fill_valid | input | 1 | Owner returns data for an outstanding fetch |
| fill_data | input | 32 | Owner data |
| rep_valid | output | 1 | Data reply valid |
| rep_dst | output | 2 | Reply destination processor |
| rep_data | output | 32 | Reply data |
| cmd_valid | output | 1 | Command to a remote cache valid |
| cmd_kind | output | 2 | 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| cmd_dst | output | 2 | Command destination processor |
| cmd_blk | output | 4 | Block the command refers to |

## Verification
One block is driven through every directory state in turn. Growing sharer sets of different shapes show whether the invalidation walk skips the requester and keeps ascending order. Fill data that differs from memory separates replies taken from the owner from replies taken from the array. A read miss after evictions from the owner and from a non-owner shows whether memory and state were written or left alone. A second block goes from not cached to owned to shared by a read miss, which shows that an owned state really records its owner.

// File: rtl/cohdir_pkg.sv
package cohdir_pkg;
    localparam int NPROC = 4;
    localparam int PW    = $clog2(NPROC);

    typedef logic [NPROC-1:0] shr_t;

    typedef enum logic [1:0] {DS_NONE = 2'd0, DS_SHARED = 2'd1, DS_OWNED = 2'd2} dstate_e;
    typedef enum logic [1:0] {RQ_READ = 2'd0, RQ_WRITE = 2'd1, RQ_EVICT = 2'd2, RQ_RSVD = 2'd3} rqkind_e;
    typedef enum logic [1:0] {CM_NOP = 2'd0, CM_INVAL = 2'd1, CM_FETCH = 2'd2, CM_FETCHINV = 2'd3} cmkind_e;
    typedef enum logic [1:0] {EN_IDLE = 2'd0, EN_INVAL = 2'd1, EN_WAIT = 2'd2} eng_e;

    typedef struct packed {
        dstate_e st;
        shr_t    shr;
    } dent_t;

    function automatic logic [PW-1:0] low_idx(shr_t m);
        logic [PW-1:0] r;
        r = '0;
        for (int i = NPROC - 1; i >= 0; i--)
            if (m[i]) r = PW'(i);
        return r;
    endfunction

    function automatic shr_t proc_bit(logic [PW-1:0] p);
        return shr_t'(1) << p;
    endfunction

    function automatic logic [31:0] init_word(int i);
        return 32'hC0DE_0000 + 32'(i);
    endfunction
endpackage

// File: rtl/cohdir_table.sv
module cohdir_table import cohdir_pkg::*; #(
    parameter int NBLK = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(NBLK)-1:0] idx,
    output dent_t                   rd_ent,
    input  logic                    we,
    input  dent_t                   wr_ent
);
    dent_t tab [NBLK];

    assign rd_ent = tab[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBLK; i++) tab[i] <= '{st: DS_NONE, shr: '0};
        end else if (we) begin
            tab[idx] <= wr_ent;
        end
    end
endmodule

// File: rtl/cohdir_store.sv
module cohdir_store import cohdir_pkg::*; #(
    parameter int NBLK = 16,
    parameter int DW   = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(NBLK)-1:0] idx,
    output logic [DW-1:0]           rd_data,
    input  logic                    we,
    input  logic [DW-1:0]           wr_data
);
    logic [DW-1:0] mem [NBLK];

    assign rd_data = mem[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBLK; i++) mem[i] <= DW'(init_word(i));
        end else if (we) begin
            mem[idx] <= wr_data;
        end
    end
endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir import cohdir_pkg::*; #(
    parameter int NBLK = 16,
    parameter int DW   = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [1:0]              req_kind,
    input  logic [PW-1:0]           req_src,
    input  logic [$clog2(NBLK)-1:0] req_blk,
    input  logic [DW-1:0]           req_data,
    input  logic                    fill_valid,
    input  logic [DW-1:0]           fill_data,
    output logic                    rep_valid,
    output logic [PW-1:0]           rep_dst,
    output logic [DW-1:0]           rep_data,
    output logic                    cmd_valid,
    output logic [1:0]              cmd_kind,
    output logic [PW-1:0]           cmd_dst,
    output logic [$clog2(NBLK)-1:0] cmd_blk
);
    localparam int BW = $clog2(NBLK);

    eng_e          st;
    logic [PW-1:0] cur_src;
    logic [BW-1:0] cur_blk;
    rqkind_e       cur_kind;
    shr_t          inv_left;
    cmkind_e       cmd_q;

    logic [BW-1:0] idx;
    dent_t         ent, ent_nx;
    logic          dir_we, mem_we, acc;
    logic [DW-1:0] mem_q, mem_d;
    rqkind_e       kind_in;
    shr_t          src_bit, cur_bit, inv_need;

    assign req_ready = (st == EN_IDLE);
    assign acc       = req_valid && req_ready;
    assign kind_in   = rqkind_e'(req_kind);
    assign src_bit   = proc_bit(req_src);
    assign cur_bit   = proc_bit(cur_src);
    assign idx       = (st == EN_IDLE) ? req_blk : cur_blk;
    assign inv_need  = ent.shr & ~src_bit;
    assign cmd_kind  = cmd_q;

    cohdir_table #(.NBLK(NBLK)) u_tab (
        .clk(clk), .rst(rst), .idx(idx), .rd_ent(ent), .we(dir_we), .wr_ent(ent_nx)
    );

    cohdir_store #(.NBLK(NBLK), .DW(DW)) u_mem (
        .clk(clk), .rst(rst), .idx(idx), .rd_data(mem_q), .we(mem_we), .wr_data(mem_d)
    );

    // Directory and memory updates: at acceptance, or when the owner's fill arrives.
    always_comb begin
        dir_we = 1'b0;
        ent_nx = ent;
        mem_we = 1'b0;
        mem_d  = fill_data;
        if (acc) begin
            unique case (kind_in)
                RQ_READ: begin
                    if (ent.st == DS_NONE) begin
                        dir_we = 1'b1; ent_nx = '{st: DS_SHARED, shr: src_bit};
                    end else if (ent.st == DS_SHARED) begin
                        dir_we = 1'b1; ent_nx = '{st: DS_SHARED, shr: ent.shr | src_bit};
                    end
                end
                RQ_WRITE: begin
                    if (ent.st != DS_OWNED) begin
                        dir_we = 1'b1; ent_nx = '{st: DS_OWNED, shr: src_bit};
                    end
                end
                RQ_EVICT: begin
                    if (ent.st == DS_OWNED && ent.shr == src_bit) begin
                        dir_we = 1'b1; ent_nx = '{st: DS_NONE, shr: '0};
                        mem_we = 1'b1; mem_d  = req_data;
                    end
                end
                default: ;
            endcase
        end else if (st == EN_WAIT && fill_valid) begin
            mem_we = 1'b1;
            dir_we = 1'b1;
            if (cur_kind == RQ_READ) ent_nx = '{st: DS_SHARED, shr: ent.shr | cur_bit};
            else                     ent_nx = '{st: DS_OWNED,  shr: cur_bit};
        end
    end

    // Sequencing of replies and remote commands.
    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= EN_IDLE;
            cur_src   <= '0;
            cur_blk   <= '0;
            cur_kind  <= RQ_READ;
            inv_left  <= '0;
            rep_valid <= 1'b0;
            rep_dst   <= '0;
            rep_data  <= '0;
            cmd_valid <= 1'b0;
            cmd_q     <= CM_NOP;
            cmd_dst   <= '0;
            cmd_blk   <= '0;
        end else begin
            rep_valid <= 1'b0;
            cmd_valid <= 1'b0;
            unique case (st)
                EN_IDLE: if (acc) begin
                    cur_src  <= req_src;
                    cur_blk  <= req_blk;
                    cur_kind <= kind_in;
                    if (kind_in == RQ_READ || kind_in == RQ_WRITE) begin
                        if (ent.st == DS_OWNED) begin
                            cmd_valid <= 1'b1;
                            cmd_q     <= (kind_in == RQ_READ) ? CM_FETCH : CM_FETCHINV;
                            cmd_dst   <= low_idx(ent.shr);
                            cmd_blk   <= req_blk;
                            st        <= EN_WAIT;
                        end else if (kind_in == RQ_WRITE && ent.st == DS_SHARED && inv_need != '0) begin
                            inv_left <= inv_need;
                            st       <= EN_INVAL;
                        end else begin
                            rep_valid <= 1'b1;
                            rep_dst   <= req_src;
                            rep_data  <= mem_q;
                        end
                    end
                end
                EN_INVAL: begin
                    if (inv_left == '0) begin
                        rep_valid <= 1'b1;
                        rep_dst   <= cur_src;
                        rep_data  <= mem_q;
                        st        <= EN_IDLE;
                    end else begin
                        cmd_valid <= 1'b1;
                        cmd_q     <= CM_INVAL;
                        cmd_dst   <= low_idx(inv_left);
                        cmd_blk   <= cur_blk;
                        inv_left  <= inv_left & ~proc_bit(low_idx(inv_left));
                    end
                end
                EN_WAIT: if (fill_valid) begin
                    rep_valid <= 1'b1;
                    rep_dst   <= cur_src;
                    rep_data  <= fill_data;
                    st        <= EN_IDLE;
                end
                default: st <= EN_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cohdir_chk.sv
module cohdir_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_kind,
    input logic       rep_valid,
    input logic       cmd_valid,
    input logic [1:0] cmd_kind
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !rep_valid && !cmd_valid));

    p_read_answer_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_kind == 2'd0) |=> (rep_valid || (cmd_valid && cmd_kind == 2'd2)));

    p_inval_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd1) |-> !req_ready);

    p_fetch_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind[1]) |-> !req_ready);

    p_evict_silent_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_kind == 2'd2) |=> (!rep_valid && !cmd_valid));

    p_no_overlap_r10: assert property (@(posedge clk) disable iff (rst)
        !(rep_valid && cmd_valid));
endmodule

bind coh_home_dir cohdir_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .rep_valid(rep_valid), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind)
);

// File: tb/sim_coh_home_dir.sv
module sim_coh_home_dir;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_src = '0;
    logic [3:0]  req_blk = '0;
    logic [31:0] req_data = '0;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_data = '0;
    logic        rep_valid;
    logic [1:0]  rep_dst;
    logic [31:0] rep_data;
    logic        cmd_valid;
    logic [1:0]  cmd_kind;
    logic [1:0]  cmd_dst;
    logic [3:0]  cmd_blk;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    coh_home_dir u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
        .fill_valid(fill_valid), .fill_data(fill_data), .rep_valid(rep_valid),
        .rep_dst(rep_dst), .rep_data(rep_data), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_dst(cmd_dst), .cmd_blk(cmd_blk)
    );

    typedef struct packed {
        logic [1:0]  kind;  logic [1:0] src; logic [3:0] blk;
        logic [31:0] wdat;  logic [31:0] fdat;
        logic        erep;  logic [1:0] edst; logic [31:0] edat; logic [3:0] ecyc;
        logic [2:0]  ncmd;
        logic [1:0]  k0; logic [1:0] d0; logic [3:0] c0;
        logic [1:0]  k1; logic [1:0] d1; logic [3:0] c1;
        logic [7:0]  tag;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VT [NV] = '{
        '{2'd0, 2'd1, 4'd2, 32'h0, 32'h0,         1'b1, 2'd1, 32'hC0DE_0002, 4'd0, 3'd0, 2'd0, 2'd0, 4'd0, 2'd0, 2'd0, 4'd0, 8'd2}, // R2
        '{2'd0, 2'd3, 4'd2, 32'h0, 32'h0,         1'b1, 2'd3, 32'hC0DE_0002, 4'd0, 3'd0, 2'd0, 2'd0, 4'd0, 2'd0, 2'd0, 4'd0, 8'd3}, // R3
        '{2'd0, 2'd0, 4'd2, 32'h0, 32'h0,         1'b1, 2'd0, 32'hC0DE_0002, 4'd0, 3'd0, 2'd0, 2'd0, 4'd0, 2'd0, 2'd0, 4'd0, 8'd3}, // R3
        '{2'd1, 2'd1, 4'd2, 32'h0, 32'h0,         1'b1, 2'd1, 32'hC0DE_0002, 4'd3, 3'd2, 2'd1, 2'd0, 4'd1, 2'd1, 2'd3, 4'd2, 8'd5}, // R5
        '{2'd0, 2'd2, 4'd2, 32'h0, 32'h1111_AAAA, 1'b1, 2'd2, 32'h1111_AAAA, 4'd1, 3'd1, 2'd2, 2'd1, 4'd0, 2'd0, 2'd0, 4'd0, 8'd6}, // R6
        '{2'd1, 2'd3, 4'd2, 32'h0, 32'h0,         1'b1, 2'd3, 32'h1111_AAAA, 4'd3, 3'd2, 2'd1, 2'd1, 4'd1, 2'd1, 2'd2, 4'd2, 8'd5}, // R5 R6
        '{2'd1, 2'd0, 4'd2, 32'h0, 32'h2222_BBBB, 1'b1, 2'd0, 32'h2222_BBBB, 4'd1, 3'd1, 2'd3, 2'd3, 4'd0, 2'd0, 2'd0, 4'd0, 8'd7}, // R7
        '{2'd2, 2'd2, 4'd2, 32'h3333_CCCC, 32'h0, 1'b0, 2'd0, 32'h0,         4'd0, 3'd0, 2'd0, 2'd0, 4'd0, 2'd0, 2'd0, 4'd0, 8'd9}, // R9
        '{2'd2, 2'd0, 4'd2, 32'h4444_DDDD, 32'h0, 1'b0, 2'd0, 32'h0,         4'd0, 3'd0, 2'd0, 2'd0, 4'd0, 2'd0, 2'd0, 4'd0, 8'd8}, // R8
        '{2'd0, 2'd1, 4'd2, 32'h0, 32'h0,         1'b1, 2'd1, 32'h4444_DDDD, 4'd0, 3'd0, 2'd0, 2'd0, 4'd0, 2'd0, 2'd0, 4'd0, 8'd8}, // R8
        '{2'd1, 2'd2, 4'd5, 32'h0, 32'h0,         1'b1, 2'd2, 32'hC0DE_0005, 4'd0, 3'd0, 2'd0, 2'd0, 4'd0, 2'd0, 2'd0, 4'd0, 8'd4}, // R4
        '{2'd0, 2'd0, 4'd5, 32'h0, 32'h5555_EEEE, 1'b1, 2'd0, 32'h5555_EEEE, 4'd1, 3'd1, 2'd2, 2'd2, 4'd0, 2'd0, 2'd0, 4'd0, 8'd4}, // R4 R6
        '{2'd1, 2'd0, 4'd5, 32'h0, 32'h0,         1'b1, 2'd0, 32'h5555_EEEE, 4'd2, 3'd1, 2'd1, 2'd2, 4'd1, 2'd0, 2'd0, 4'd0, 8'd5}, // R5 requester skipped
        '{2'd2, 2'd1, 4'd7, 32'h7777_0000, 32'h0, 1'b0, 2'd0, 32'h0,         4'd0, 3'd0, 2'd0, 2'd0, 4'd0, 2'd0, 2'd0, 4'd0, 8'd9}, // R9
        '{2'd0, 2'd3, 4'd7, 32'h0, 32'h0,         1'b1, 2'd3, 32'hC0DE_0007, 4'd0, 3'd0, 2'd0, 2'd0, 4'd0, 2'd0, 2'd0, 4'd0, 8'd9}, // R9
        '{2'd0, 2'd0, 4'd15, 32'h0, 32'h0,        1'b1, 2'd0, 32'hC0DE_000F, 4'd0, 3'd0, 2'd0, 2'd0, 4'd0, 2'd0, 2'd0, 4'd0, 8'd1}, // R1
        '{2'd3, 2'd0, 4'd0, 32'hDEAD_0000, 32'h0, 1'b0, 2'd0, 32'h0,         4'd0, 3'd0, 2'd0, 2'd0, 4'd0, 2'd0, 2'd0, 4'd0, 8'd9}, // R9
        '{2'd1, 2'd0, 4'd0, 32'h0, 32'h0,         1'b1, 2'd0, 32'hC0DE_0000, 4'd0, 3'd0, 2'd0, 2'd0, 4'd0, 2'd0, 2'd0, 4'd0, 8'd9}  // R9
    };

    task automatic chk(input bit ok, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic run_req(input vec_t v);
        int nrep = 0;
        int nc = 0;
        int rcyc = -1;
        logic [1:0] rdst = '0;
        logic [31:0] rdat = '0;
        logic [1:0] ck [4];
        logic [1:0] cd [4];
        int cc [4];
        bit blk_ok = 1'b1;
        bit busy_ok = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_kind = v.kind; req_src = v.src;
        req_blk = v.blk; req_data = v.wdat;
        @(posedge clk);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            fill_valid = 1'b0;
            if (rep_valid) begin
                nrep++; rcyc = i; rdst = rep_dst; rdat = rep_data;
            end
            if (cmd_valid) begin
                if (nc < 4) begin ck[nc] = cmd_kind; cd[nc] = cmd_dst; cc[nc] = i; end
                nc++;
                if (cmd_blk != v.blk) blk_ok = 1'b0;
                if (req_ready) busy_ok = 1'b0;
                if (cmd_kind[1]) begin fill_valid = 1'b1; fill_data = v.fdat; end
            end
        end
        chk(nrep == int'(v.erep), int'(v.tag), "reply count", nrep, v.erep);
        if (v.erep) begin
            chk(rdst == v.edst, int'(v.tag), "reply dst", rdst, v.edst);
            chk(rdat == v.edat, int'(v.tag), "reply data", rdat, v.edat);
            chk(rcyc == int'(v.ecyc), int'(v.tag), "reply cycle", rcyc, v.ecyc);
        end
        chk(nc == int'(v.ncmd), int'(v.tag), "command count", nc, v.ncmd);
        if (v.ncmd >= 1 && nc >= 1) begin
            chk(ck[0] == v.k0 && cd[0] == v.d0 && cc[0] == int'(v.c0), int'(v.tag),
                "command0 kind/dst/cyc", {ck[0], cd[0], 4'(cc[0])}, {v.k0, v.d0, v.c0});
            chk(busy_ok, 8, "ready low while busy (R10 R5 R6)", busy_ok, 1);
            chk(blk_ok, 10, "command block (R10)", blk_ok, 1);
        end
        if (v.ncmd >= 2 && nc >= 2)
            chk(ck[1] == v.k1 && cd[1] == v.d1 && cc[1] == int'(v.c1), int'(v.tag),
                "command1 kind/dst/cyc", {ck[1], cd[1], 4'(cc[1])}, {v.k1, v.d1, v.c1});
        chk(req_ready == 1'b1, int'(v.tag), "ready after request", req_ready, 1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        chk(req_ready && !rep_valid && !cmd_valid, 1, "reset outputs",
            {req_ready, rep_valid, cmd_valid}, 3'b100);

        for (int n = 0; n < NV; n++) run_req(VT[n]);

        // R11: stray fill while idle
        @(negedge clk); fill_valid = 1'b1; fill_data = 32'h9999_9999;
        @(negedge clk); fill_valid = 1'b0;
        chk(!rep_valid && !cmd_valid && req_ready, 11, "stray fill outputs",
            {rep_valid, cmd_valid, req_ready}, 3'b001);
        run_req('{2'd0, 2'd1, 4'd9, 32'h0, 32'h0, 1'b1, 2'd1, 32'hC0DE_0009, 4'd0, 3'd0,
                  2'd0, 2'd0, 4'd0, 2'd0, 2'd0, 4'd0, 8'd11});

        // R6 then R1: fetch outstanding, reset abandons it (block 5 owned by 0)
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_src = 2'd1; req_blk = 4'd5;
        @(negedge clk); req_valid = 1'b0;
        chk(cmd_valid && cmd_kind == 2'd2 && cmd_dst == 2'd0 && !req_ready, 6,
            "fetch to owner", {cmd_valid, cmd_kind, cmd_dst, req_ready}, 6'b1_10_00_0);
        @(negedge clk);
        chk(!req_ready, 6, "ready held while waiting", req_ready, 0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(req_ready && !rep_valid && !cmd_valid, 1, "outputs after mid-wait reset",
            {req_ready, rep_valid, cmd_valid}, 3'b100);
        run_req('{2'd0, 2'd2, 4'd5, 32'h0, 32'h0, 1'b1, 2'd2, 32'hC0DE_0005, 4'd0, 3'd0,
                  2'd0, 2'd0, 4'd0, 2'd0, 2'd0, 4'd0, 8'd1});

        done = 1'b1;
        finish_run();
    end
endmodule